// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block buffers 18-bit words between a write clock domain and a read clock domain that are unrelated. The storage is an internal array of 2^AW words. It is written on the write clock and read into a registered output on the read clock. The write pointer and the read pointer cross between the domains as Gray-coded values through synchronisers. Full, empty and half-full are derived from these pointers.

The output timing is chosen by the level of `fwft_sel` while master reset is held, and that choice stays in force until the next master reset:
- **Standard mode:** a word is moved to `rd_data` only on a read request.
- **Fall-through mode:** the oldest stored word is presented on `rd_data` without any request, and a read request consumes it.

A partial reset empties the FIFO but keeps the chosen mode. A retransmit pulse on the read side rewinds the read pointer to location zero and leaves the write pointer alone. The same data can then be read again from the start of the array.

Top module: `dc_fifo_rt`

## Requirements
- R1: While `mst_rst` is high, both pointers and the output register are cleared to zero, and the level of `fwft_sel` is latched as the mode (1 = fall-through, 0 = standard). After master reset the FIFO reads as empty and not full, and `rd_data` is zero.
- R2: Status encodings:
  - Standard mode: `wr_stat` is 1 when there is room and 0 when full; `rd_stat` is 1 when a word can be read and 0 when empty.
  - Fall-through mode: `wr_stat` is 0 when there is room and 1 when full; `rd_stat` is 0 when a valid word stands on `rd_data` and 1 when it does not.
- R3: In fall-through mode, a word written into an empty FIFO appears on `rd_data` with no `rd_en`. `rd_stat` drops to 0 on the same read-clock edge that loads the word. The word stays there until `rd_en` consumes it.
- R4: While `part_rst` is high, both pointers and the output register are cleared. The mode latched at the last master reset is kept, and `fwft_sel` is ignored.
- R5: Retransmit:
  - A high `retx` on a read-clock edge sets the read pointer to zero and leaves the write pointer unchanged.
  - From that edge, the empty indication is forced (standard `rd_stat` = 0, fall-through `rd_stat` = 1) for RT_HOLD read cycles.
  - After that, the words are read again from location zero, and later writes continue after the last word written.
- R6: A write happens only on a `wr_clk` rising edge with `wr_en` high and the FIFO not full. In standard mode, a read on a `rd_clk` rising edge with `rd_en` high and the FIFO not empty loads the next word into `rd_data` on that edge.
- R7: Words leave in the order they were written, across several fill levels and in both modes.
- R8: `half_n` is 0 when the write side counts more than 2^(AW-1) stored words, and 1 otherwise.
- R9: With `out_en` low, `rd_data` reads zero. Raising `out_en` again shows the held word, unchanged.
- R10: Overrun and underrun are ignored:
  - A write while full changes neither the write pointer nor the stored data.
  - A standard-mode read while empty changes neither the read pointer nor `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mst_rst | input | 1 | Master reset, synchronous, active high, sampled in both domains |
| part_rst | input | 1 | Partial reset, synchronous, active high, keeps the mode |
| fwft_sel | input | 1 | Mode select, sampled only during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| wr_stat | output | 1 | Full flag (standard) or input-ready (fall-through) |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit request, read domain |
| out_en | input | 1 | Output gate for `rd_data` |
| rd_data | output | DW | Read data, zero when `out_en` is low |
| rd_stat | output | 1 | Empty flag (standard) or output-ready (fall-through) |
| half_n | output | 1 | Low when more than half full |

## Verification
Each result has a fixed latency after its stimulus:
- A write edge changes `wr_stat` and `half_n` before the following write-clock negative edge.
- The same write reaches the read side after SYNC_STAGES read edges, which is when standard `rd_stat` rises. In fall-through mode the word and `rd_stat` follow one read edge later.
- A standard read shows its word after the one read edge that requests it.
- A retransmit forces the empty indication after the edge that samples it.

The bench samples every output on the negative edge of the clock that owns it. It samples immediately where the latency is a single edge. Where the latency crosses domains, it polls the status output with a bounded number of read cycles, and it fails if that bound is passed. For the checks that something is ignored, the bench reads the next word through the normal port and compares it against the value the unchanged pointer must give.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifo_mode_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
// Multi-stage synchroniser for a Gray-coded pointer.
module dcf_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_g2b.sv
`timescale 1ns/1ps
// Gray to binary conversion, one XOR reduction per bit.
module dcf_g2b #(
  parameter int W = 5
) (
  input  logic [W-1:0] gray,
  output logic [W-1:0] bin
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin[i] = ^gray[W-1:i];
  end
endmodule

// File: rtl/dcf_wr_ctl.sv
`timescale 1ns/1ps
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          mst_rst,
  input  logic          part_rst,
  input  logic          mode_sel,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_async,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          half_n,
  output fifo_mode_e    mode
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] HALF = PW'(1 << (AW - 1));

  logic          rst;
  logic [PW-1:0] rq, rbin, wbin, wbin_nx, fill;

  assign rst = mst_rst | part_rst;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rsync (
    .clk (clk),
    .rst (rst),
    .d   (rgray_async),
    .q   (rq)
  );

  dcf_g2b #(.W(PW)) u_rconv (
    .gray (rq),
    .bin  (rbin)
  );

  // Full: top two Gray bits inverted, the rest equal.
  assign full    = (wgray == {~rq[AW:AW-1], rq[AW-2:0]});
  assign we      = wr_en & ~full;
  assign wbin_nx = wbin + PW'(we);
  assign waddr   = wbin[AW-1:0];
  assign fill    = wbin - rbin;
  assign half_n  = !(fill > HALF);

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (mst_rst) mode <= fifo_mode_e'(mode_sel);
  end
endmodule

// File: rtl/dcf_rd_ctl.sv
`timescale 1ns/1ps
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RT_HOLD     = 2
) (
  input  logic          clk,
  input  logic          mst_rst,
  input  logic          part_rst,
  input  logic          mode_sel,
  input  logic          rd_en,
  input  logic          retx,
  input  logic [AW:0]   wgray_async,
  output logic          fetch,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty_ind,
  output fifo_mode_e    mode
);
  localparam int PW = AW + 1;
  localparam int HW = $clog2(RT_HOLD + 1);

  logic          rst, mem_empty, hold, ovalid;
  logic [PW-1:0] wq, rbin, rbin_nx;
  logic [HW-1:0] hold_cnt;

  assign rst = mst_rst | part_rst;

  dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wsync (
    .clk (clk),
    .rst (rst),
    .d   (wgray_async),
    .q   (wq)
  );

  assign mem_empty = (rgray == wq);
  assign hold      = (hold_cnt != '0);

  always_comb begin
    if (mode == MODE_FWFT)
      fetch = ~mem_empty & ~hold & ~retx & (~ovalid | rd_en);
    else
      fetch = rd_en & ~mem_empty & ~hold & ~retx;
  end

  assign rbin_nx   = rbin + PW'(fetch);
  assign raddr     = rbin[AW-1:0];
  assign empty_ind = (mode == MODE_FWFT) ? ~ovalid : (mem_empty | hold);

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin     <= '0;
      rgray    <= '0;
      hold_cnt <= '0;
      ovalid   <= 1'b0;
    end else if (retx) begin
      rbin     <= '0;
      rgray    <= '0;
      hold_cnt <= HW'(RT_HOLD);
      ovalid   <= 1'b0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      if (hold) hold_cnt <= hold_cnt - 1'b1;
      if (fetch)      ovalid <= 1'b1;
      else if (rd_en) ovalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (mst_rst) mode <= fifo_mode_e'(mode_sel);
  end
endmodule

// File: rtl/dc_fifo_rt.sv
`timescale 1ns/1ps
module dc_fifo_rt
  import dcf_pkg::*;
#(
  parameter int DW          = 18,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RT_HOLD     = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mst_rst,
  input  logic          part_rst,
  input  logic          fwft_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          wr_stat,
  input  logic          rd_en,
  input  logic          retx,
  input  logic          out_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  output logic          half_n
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] q_reg;
  logic          we, wr_full, fetch, empty_ind, rd_fwft;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray;
  fifo_mode_e    wr_mode, rd_mode;

  dcf_wr_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk         (wr_clk),
    .mst_rst     (mst_rst),
    .part_rst    (part_rst),
    .mode_sel    (fwft_sel),
    .wr_en       (wr_en),
    .rgray_async (rgray),
    .we          (we),
    .waddr       (waddr),
    .wgray       (wgray),
    .full        (wr_full),
    .half_n      (half_n),
    .mode        (wr_mode)
  );

  dcf_rd_ctl #(.AW(AW), .SYNC_STAGES(SYNC_STAGES), .RT_HOLD(RT_HOLD)) u_rd (
    .clk         (rd_clk),
    .mst_rst     (mst_rst),
    .part_rst    (part_rst),
    .mode_sel    (fwft_sel),
    .rd_en       (rd_en),
    .retx        (retx),
    .wgray_async (wgray),
    .fetch       (fetch),
    .raddr       (raddr),
    .rgray       (rgray),
    .empty_ind   (empty_ind),
    .mode        (rd_mode)
  );

  // Simple dual-port array: one write port, one registered read port.
  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wr_data;
  end

  always_ff @(posedge rd_clk) begin
    if (mst_rst | part_rst) q_reg <= '0;
    else if (fetch)         q_reg <= mem[raddr];
  end

  assign rd_fwft = (rd_mode == MODE_FWFT);
  assign wr_stat = (wr_mode == MODE_FWFT) ? wr_full : ~wr_full;
  assign rd_stat = rd_fwft ? empty_ind : ~empty_ind;
  assign rd_data = out_en ? q_reg : '0;
endmodule

// File: rtl/dc_fifo_rt_chk.sv
`timescale 1ns/1ps
module dc_fifo_rt_chk #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mst_rst,
  input logic          part_rst,
  input logic          wr_en,
  input logic          rd_en,
  input logic          retx,
  input logic          rd_stat,
  input logic          wr_full,
  input logic          rd_fwft,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rgray,
  input logic [DW-1:0] q_reg
);
  // R1
  mrst_clear_chk: assert property (@(posedge rd_clk)
    mst_rst |=> (q_reg == '0 && rgray == '0));

  // R10
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
    (wr_full && wr_en) |=> $stable(wgray));

  // R10
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
    (!rd_fwft && !rd_stat && rd_en && !retx) |=> $stable(rgray));

  // R5
  rt_rewind_chk: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
    retx |=> (rgray == '0));

  // R5
  rt_flag_chk: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
    retx |=> (rd_stat == rd_fwft));

  // R3
  fwft_hold_chk: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
    (rd_fwft && !rd_stat && !rd_en && !retx) |=> (!rd_stat && $stable(q_reg)));

  // R6
  wr_gray_step_chk: assert property (@(posedge wr_clk) disable iff (mst_rst || part_rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R6
  rd_gray_step_chk: assert property (@(posedge rd_clk) disable iff (mst_rst || part_rst)
    !$past(retx) |-> ($countones(rgray ^ $past(rgray)) <= 1));
endmodule

bind dc_fifo_rt dc_fifo_rt_chk #(.DW(DW), .AW(AW)) u_chk (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .mst_rst  (mst_rst),
  .part_rst (part_rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .retx     (retx),
  .rd_stat  (rd_stat),
  .wr_full  (wr_full),
  .rd_fwft  (rd_fwft),
  .wgray    (wgray),
  .rgray    (rgray),
  .q_reg    (q_reg)
);

// File: tb/dc_fifo_rt_tb.sv
`timescale 1ns/1ps
module dc_fifo_rt_tb;
  localparam int DW    = 18;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          mst_rst = 1'b1, part_rst = 1'b0, fwft_sel = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0, out_en = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_stat, rd_stat, half_n;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] sb [$];

  dc_fifo_rt #(.DW(DW), .AW(AW)) u_dut (
    .wr_clk (wr_clk), .rd_clk (rd_clk), .mst_rst (mst_rst), .part_rst (part_rst),
    .fwft_sel (fwft_sel), .wr_en (wr_en), .wr_data (wr_data), .wr_stat (wr_stat),
    .rd_en (rd_en), .retx (retx), .out_en (out_en), .rd_data (rd_data),
    .rd_stat (rd_stat), .half_n (half_n)
  );

  always #5 wr_clk = ~wr_clk;
  initial begin
    #3;
    forever #5 rd_clk = ~rd_clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: one write request; the scoreboard takes the word only if the model has room.
  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    if (sb.size() < DEPTH) sb.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_stat(input logic lvl, input int maxc, input string tag);
    int n = 0;
    while (rd_stat !== lvl && n < maxc) begin
      @(negedge rd_clk);
      n++;
    end
    chk(tag, rd_stat, lvl);
  endtask

  // Monitor, standard mode: request, then compare on the following read negedge.
  task automatic pop_std(input string tag);
    @(negedge rd_clk);
    wait_stat(1'b1, 8, tag);
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    chk(tag, rd_data, sb.pop_front());
  endtask

  // Monitor, fall-through mode: compare the presented word, then consume it.
  task automatic pop_fwft(input string tag);
    @(negedge rd_clk);
    wait_stat(1'b0, 8, tag);
    chk(tag, rd_data, sb.pop_front());
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_retx();
    @(negedge rd_clk);
    retx = 1'b1;
    @(negedge rd_clk);
    retx = 1'b0;
  endtask

  task automatic do_rst(input bit master, input logic sel);
    @(negedge wr_clk);
    if (master) mst_rst = 1'b1;
    else        part_rst = 1'b1;
    fwft_sel = sel;
    repeat (4) @(negedge wr_clk);
    mst_rst = 1'b0;
    part_rst = 1'b0;
    sb.delete();
    repeat (3) @(negedge wr_clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #1500000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge wr_clk);
    mst_rst = 1'b0;
    repeat (3) @(negedge wr_clk);

    // R1 / R2 reset state, standard mode
    chk("R1 rd_data after master reset", rd_data, 0);
    chk("R2 std empty", rd_stat, 0);
    chk("R2 std not full", wr_stat, 1);
    chk("R8 half_n empty", half_n, 1);

    // R6 / R7 basic ordering
    for (int i = 0; i < 5; i++) push(DW'(18'h01000 + i));
    for (int i = 0; i < 5; i++) pop_std("R6 R7 std read");
    repeat (3) @(negedge rd_clk);
    chk("R2 std empty after drain", rd_stat, 0);

    // R10 read while empty
    @(negedge rd_clk);
    rd_en = 1'b1;
    repeat (4) @(negedge rd_clk);
    rd_en = 1'b0;
    chk("R10 rd_data kept on empty read", rd_data, 18'h01004);
    chk("R10 still empty", rd_stat, 0);
    push(18'h2AAAA);
    pop_std("R10 read pointer unchanged");

    // R4 partial reset keeps standard mode, fwft_sel ignored
    do_rst(1'b0, 1'b1);
    chk("R4 output cleared", rd_data, 0);
    push(18'h00055);
    repeat (6) @(negedge rd_clk);
    chk("R4 std mode kept: data flag", rd_stat, 1);
    chk("R4 std mode kept: no fall-through", rd_data, 0);
    pop_std("R4 word after partial reset");

    // R8 half-full boundary, R2 full, R10 overrun
    for (int i = 0; i < 8; i++) push(DW'(18'h00300 + i));
    repeat (3) @(negedge wr_clk);
    chk("R8 half_n at half", half_n, 1);
    push(18'h00308);
    chk("R8 half_n above half", half_n, 0);
    for (int i = 9; i < DEPTH; i++) push(DW'(18'h00300 + i));
    chk("R2 std full", wr_stat, 0);
    push(18'h3FFFF);
    for (int i = 0; i < DEPTH; i++) pop_std("R10 R7 overrun ignored");
    repeat (4) @(negedge rd_clk);
    chk("R2 empty after full drain", rd_stat, 0);

    // R9 output gate
    push(18'h15A5A);
    pop_std("R9 word");
    @(negedge rd_clk);
    out_en = 1'b0;
    #1;
    chk("R9 gated", rd_data, 0);
    out_en = 1'b1;
    #1;
    chk("R9 restored", rd_data, 18'h15A5A);

    // R5 retransmit, standard
    do_rst(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) push(DW'(18'h00100 + i));
    for (int i = 0; i < 4; i++) pop_std("R5 first pass");
    pulse_retx();
    chk("R5 std empty forced", rd_stat, 0);
    for (int i = 0; i < 4; i++) sb.push_back(DW'(18'h00100 + i));
    for (int i = 0; i < 4; i++) pop_std("R5 reread");
    push(18'h00777);
    pop_std("R5 write pointer kept");

    // R1 / R2 / R3 fall-through mode
    do_rst(1'b1, 1'b1);
    chk("R1 rd_data zero", rd_data, 0);
    chk("R2 fwft not ready", rd_stat, 1);
    chk("R2 fwft input ready", wr_stat, 0);
    push(18'h0ABCD);
    @(negedge rd_clk);
    wait_stat(1'b0, 8, "R3 fall-through ready");
    chk("R3 fall-through data", rd_data, 18'h0ABCD);
    pop_fwft("R3 consume");
    for (int i = 0; i < 3; i++) push(DW'(18'h00500 + i));
    for (int i = 0; i < 3; i++) pop_fwft("R7 fwft order");
    repeat (4) @(negedge rd_clk);
    chk("R2 fwft empty again", rd_stat, 1);

    // R4 partial reset keeps fall-through
    do_rst(1'b0, 1'b0);
    chk("R4 fwft mode kept", rd_stat, 1);
    push(18'h01234);
    @(negedge rd_clk);
    wait_stat(1'b0, 8, "R4 fwft ready");
    chk("R4 fwft data", rd_data, 18'h01234);
    pop_fwft("R4 consume");

    // R5 retransmit, fall-through
    do_rst(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) push(DW'(18'h00600 + i));
    for (int i = 0; i < 3; i++) pop_fwft("R5 fwft first pass");
    repeat (2) @(negedge rd_clk);
    pulse_retx();
    chk("R5 fwft not ready forced", rd_stat, 1);
    for (int i = 0; i < 3; i++) sb.push_back(DW'(18'h00600 + i));
    for (int i = 0; i < 3; i++) pop_fwft("R5 fwft reread");

    // R1 master reset clears a held word
    push(18'h2F0F0);
    @(negedge rd_clk);
    wait_stat(1'b0, 8, "R1 pre-reset word");
    do_rst(1'b1, 1'b0);
    chk("R1 output cleared", rd_data, 0);
    chk("R1 std empty", rd_stat, 0);

    finish_run();
  end
endmodule